// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block is the directory controller on the home node of a distributed shared memory. It keeps one entry for each memory line. The entry holds a line state, an owner node number, a bit vector of sharing nodes and the number of a node whose request is still pending. Requester nodes send read, read-exclusive and upgrade requests. For each accepted request the block chooses one reply: plain data, exclusive data, an upgrade acknowledge, a forward to the current owner, a negative acknowledge (retry) or a bus error. A reply to a write request may also carry invalidations for the other sharers. The block then rewrites the entry.

Remote owners report back on a second port. A sharing writeback closes a forwarded read. An ownership transfer closes a forwarded read-exclusive. A poison mark flags a line whose page has migrated. Messages are always taken, with no back-pressure. A request stalls only when a message to the same line arrives in the same cycle. Every response is registered and appears one clock after the request is accepted.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every line is Unowned with an empty sharer vector. rsp_valid and inv_valid are low, and req_ready is high while no message is present.
- R2: A read (req_kind 0) to an Unowned line replies DATA (rsp_kind 1). The line becomes Exclusive, owned by the requester.
- R3: A read to a Shared line replies DATA, keeps the line Shared and adds the requester to the sharer vector.
- R4: A read from a node other than the owner of an Exclusive line replies FWD (rsp_kind 4), with rsp_owner set to the owner. The line then turns Busy-Shared. A sharing writeback (msg_kind 0) makes it Shared, with both the old owner and the requester as sharers.
- R5: A read-exclusive (req_kind 1) or an upgrade (req_kind 2) to a Shared line raises inv_valid, with inv_mask holding the sharers other than the requester (bit n stands for node n). inv_valid stays low when that set is empty. The reply is EXDATA (rsp_kind 2) for read-exclusive and UPACK (rsp_kind 3) for upgrade. The line becomes Exclusive to the requester.
- R6: A read-exclusive or an upgrade from a non-owner to an Exclusive line replies FWD with the owner and turns the line Busy-Exclusive. An ownership transfer (msg_kind 1) then makes the requester the Exclusive owner.
- R7: A request from the owner of its own Exclusive line leaves the entry unchanged. It replies DATA for a read, EXDATA for a read-exclusive and UPACK for an upgrade.
- R8: Any request to a line in Busy-Shared, Busy-Exclusive or Wait replies NACK (rsp_kind 5) and leaves the entry unchanged.
- R9: A poison mark (msg_kind 2) makes an Unowned, Shared or Exclusive line Poisoned, and makes a Busy line Wait. A writeback or transfer to a Wait line makes it Poisoned. Every request to a Poisoned line replies BERR (rsp_kind 6).
- R10: A message whose kind does not match the line's state (for example a writeback to a Busy-Exclusive or Exclusive line) has no effect.
- R11: When a message and a request name the same line in one cycle, req_ready is low and the message is applied first. When they name different lines, both are taken in that cycle. Each accepted request produces exactly one response, one clock later.
- R12: A read-exclusive or an upgrade to an Unowned line replies EXDATA and makes the requester the Exclusive owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 treated as read |
| req_node | input | 4 | Requesting node |
| req_line | input | 6 | Line addressed |
| msg_valid | input | 1 | Owner message present (always taken) |
| msg_kind | input | 2 | 0 sharing writeback, 1 ownership transfer, 2 poison mark, 3 no-op |
| msg_line | input | 6 | Line the message concerns |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 3 | 1 DATA, 2 EXDATA, 3 UPACK, 4 FWD, 5 NACK, 6 BERR |
| rsp_node | output | 4 | Node the response goes to |
| rsp_line | output | 6 | Line of the response |
| rsp_owner | output | 4 | Owner the request is forwarded to (FWD only) |
| inv_valid | output | 1 | Invalidations issued with this response |
| inv_mask | output | 16 | Nodes to invalidate |
| inv_line | output | 6 | Line to invalidate |

## Verification
The assertions hold on every cycle. They check that each accepted request yields a response on the next clock and that no response appears otherwise. They also check that invalidations come only with an exclusive-data or upgrade reply and never target the requester, that a forward never points back at the requester, and that a same-line collision holds the request off. The state transitions are not visible at the ports, so only the bench's scenarios can show them. Each scenario reads a state back through later replies: a forward shows the recorded owner, an invalidation mask shows the sharer set, and a NACK or BERR shows a Busy, Wait or Poisoned line. The same method shows that mismatched messages leave a line untouched.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;

   typedef enum logic [2:0] {
      LS_UNOWNED = 3'd0,
      LS_SHARED  = 3'd1,
      LS_EXCL    = 3'd2,
      LS_POISON  = 3'd3,
      LS_BUSY_SH = 3'd4,
      LS_BUSY_EX = 3'd5,
      LS_WAIT    = 3'd6
   } line_state_e;

   typedef enum logic [1:0] {
      RQ_READ = 2'd0,
      RQ_RDEX = 2'd1,
      RQ_UPGR = 2'd2,
      RQ_RSVD = 2'd3
   } req_kind_e;

   typedef enum logic [1:0] {
      MS_SHWB   = 2'd0,
      MS_XFER   = 2'd1,
      MS_POISON = 2'd2,
      MS_NOP    = 2'd3
   } msg_kind_e;

   typedef enum logic [2:0] {
      RS_IDLE   = 3'd0,
      RS_DATA   = 3'd1,
      RS_EXDATA = 3'd2,
      RS_UPACK  = 3'd3,
      RS_FWD    = 3'd4,
      RS_NACK   = 3'd5,
      RS_BERR   = 3'd6
   } rsp_kind_e;

   function automatic logic is_transient(line_state_e s);
      return (s == LS_BUSY_SH) || (s == LS_BUSY_EX) || (s == LS_WAIT);
   endfunction

endpackage

// File: rtl/hd_store.sv
module hd_store
   import home_dir_pkg::*;
#(
   parameter int LINES  = 64,
   parameter int NODES  = 16,
   parameter int NODE_W = 4,
   parameter int LINE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   // lookup port for the request path
   input  logic [LINE_W-1:0] a_line,
   output line_state_e       a_st,
   output logic [NODE_W-1:0] a_own,
   output logic [NODES-1:0]  a_vec,
   output logic [NODE_W-1:0] a_pend,
   input  logic              a_we,
   input  line_state_e       a_st_n,
   input  logic [NODE_W-1:0] a_own_n,
   input  logic [NODES-1:0]  a_vec_n,
   input  logic [NODE_W-1:0] a_pend_n,
   // lookup port for the message path
   input  logic [LINE_W-1:0] b_line,
   output line_state_e       b_st,
   output logic [NODE_W-1:0] b_own,
   output logic [NODES-1:0]  b_vec,
   output logic [NODE_W-1:0] b_pend,
   input  logic              b_we,
   input  line_state_e       b_st_n,
   input  logic [NODE_W-1:0] b_own_n,
   input  logic [NODES-1:0]  b_vec_n,
   input  logic [NODE_W-1:0] b_pend_n
);

   line_state_e       st_arr   [LINES];
   logic [NODE_W-1:0] own_arr  [LINES];
   logic [NODES-1:0]  vec_arr  [LINES];
   logic [NODE_W-1:0] pend_arr [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_ent
      localparam logic [LINE_W-1:0] IDX = LINE_W'(i);
      line_state_e       st_q;
      logic [NODE_W-1:0] own_q;
      logic [NODES-1:0]  vec_q;
      logic [NODE_W-1:0] pend_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q   <= LS_UNOWNED;
            own_q  <= '0;
            vec_q  <= '0;
            pend_q <= '0;
         end else if (a_we && a_line == IDX) begin
            st_q   <= a_st_n;
            own_q  <= a_own_n;
            vec_q  <= a_vec_n;
            pend_q <= a_pend_n;
         end else if (b_we && b_line == IDX) begin
            st_q   <= b_st_n;
            own_q  <= b_own_n;
            vec_q  <= b_vec_n;
            pend_q <= b_pend_n;
         end
      end

      assign st_arr[i]   = st_q;
      assign own_arr[i]  = own_q;
      assign vec_arr[i]  = vec_q;
      assign pend_arr[i] = pend_q;
   end

   assign a_st   = st_arr[a_line];
   assign a_own  = own_arr[a_line];
   assign a_vec  = vec_arr[a_line];
   assign a_pend = pend_arr[a_line];
   assign b_st   = st_arr[b_line];
   assign b_own  = own_arr[b_line];
   assign b_vec  = vec_arr[b_line];
   assign b_pend = pend_arr[b_line];

endmodule

// File: rtl/hd_req_fsm.sv
module hd_req_fsm
   import home_dir_pkg::*;
#(
   parameter int NODES  = 16,
   parameter int NODE_W = 4
) (
   input  req_kind_e         kind,
   input  logic [NODE_W-1:0] node,
   input  line_state_e       cur_st,
   input  logic [NODE_W-1:0] cur_own,
   input  logic [NODES-1:0]  cur_vec,
   input  logic [NODE_W-1:0] cur_pend,
   output logic              wr,
   output line_state_e       nxt_st,
   output logic [NODE_W-1:0] nxt_own,
   output logic [NODES-1:0]  nxt_vec,
   output logic [NODE_W-1:0] nxt_pend,
   output rsp_kind_e         rk,
   output logic [NODE_W-1:0] fwd,
   output logic [NODES-1:0]  inv
);

   logic [NODES-1:0] me;
   logic             want_ex;

   assign me      = {{(NODES-1){1'b0}}, 1'b1} << node;
   assign want_ex = (kind == RQ_RDEX) || (kind == RQ_UPGR);

   always_comb begin
      wr       = 1'b0;
      nxt_st   = cur_st;
      nxt_own  = cur_own;
      nxt_vec  = cur_vec;
      nxt_pend = cur_pend;
      rk       = RS_NACK;
      fwd      = '0;
      inv      = '0;
      case (cur_st)
         LS_POISON: rk = RS_BERR;
         LS_UNOWNED: begin
            wr      = 1'b1;
            nxt_st  = LS_EXCL;
            nxt_own = node;
            nxt_vec = me;
            rk      = want_ex ? RS_EXDATA : RS_DATA;
         end
         LS_SHARED: begin
            wr = 1'b1;
            if (!want_ex) begin
               nxt_vec = cur_vec | me;
               rk      = RS_DATA;
            end else begin
               inv     = cur_vec & ~me;
               nxt_st  = LS_EXCL;
               nxt_own = node;
               nxt_vec = me;
               rk      = (kind == RQ_UPGR) ? RS_UPACK : RS_EXDATA;
            end
         end
         LS_EXCL: begin
            if (cur_own == node) begin
               if (kind == RQ_UPGR)      rk = RS_UPACK;
               else if (kind == RQ_RDEX) rk = RS_EXDATA;
               else                      rk = RS_DATA;
            end else begin
               wr       = 1'b1;
               nxt_pend = node;
               nxt_st   = want_ex ? LS_BUSY_EX : LS_BUSY_SH;
               fwd      = cur_own;
               rk       = RS_FWD;
            end
         end
         default: rk = RS_NACK;
      endcase
   end

endmodule

// File: rtl/hd_msg_fsm.sv
module hd_msg_fsm
   import home_dir_pkg::*;
#(
   parameter int NODES  = 16,
   parameter int NODE_W = 4
) (
   input  msg_kind_e         kind,
   input  line_state_e       cur_st,
   input  logic [NODE_W-1:0] cur_own,
   input  logic [NODES-1:0]  cur_vec,
   input  logic [NODE_W-1:0] cur_pend,
   output logic              wr,
   output line_state_e       nxt_st,
   output logic [NODE_W-1:0] nxt_own,
   output logic [NODES-1:0]  nxt_vec,
   output logic [NODE_W-1:0] nxt_pend
);

   localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

   always_comb begin
      wr       = 1'b0;
      nxt_st   = cur_st;
      nxt_own  = cur_own;
      nxt_vec  = cur_vec;
      nxt_pend = cur_pend;
      case (kind)
         MS_SHWB: begin
            if (cur_st == LS_BUSY_SH) begin
               wr      = 1'b1;
               nxt_st  = LS_SHARED;
               nxt_vec = (ONE << cur_own) | (ONE << cur_pend);
            end else if (cur_st == LS_WAIT) begin
               wr      = 1'b1;
               nxt_st  = LS_POISON;
               nxt_vec = '0;
            end
         end
         MS_XFER: begin
            if (cur_st == LS_BUSY_EX) begin
               wr      = 1'b1;
               nxt_st  = LS_EXCL;
               nxt_own = cur_pend;
               nxt_vec = ONE << cur_pend;
            end else if (cur_st == LS_WAIT) begin
               wr      = 1'b1;
               nxt_st  = LS_POISON;
               nxt_vec = '0;
            end
         end
         MS_POISON: begin
            if (cur_st == LS_BUSY_SH || cur_st == LS_BUSY_EX) begin
               wr     = 1'b1;
               nxt_st = LS_WAIT;
            end else if (!is_transient(cur_st) && cur_st != LS_POISON) begin
               wr      = 1'b1;
               nxt_st  = LS_POISON;
               nxt_vec = '0;
            end
         end
         default: wr = 1'b0;
      endcase
   end

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
   import home_dir_pkg::*;
#(
   parameter  int NODES  = 16,
   parameter  int LINES  = 64,
   localparam int NODE_W = $clog2(NODES),
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [NODE_W-1:0] req_node,
   input  logic [LINE_W-1:0] req_line,
   input  logic              msg_valid,
   input  logic [1:0]        msg_kind,
   input  logic [LINE_W-1:0] msg_line,
   output logic              rsp_valid,
   output logic [2:0]        rsp_kind,
   output logic [NODE_W-1:0] rsp_node,
   output logic [LINE_W-1:0] rsp_line,
   output logic [NODE_W-1:0] rsp_owner,
   output logic              inv_valid,
   output logic [NODES-1:0]  inv_mask,
   output logic [LINE_W-1:0] inv_line
);

   // elaboration-time parameter checks
   if (NODES < 2 || (1 << NODE_W) != NODES) begin : g_bad_nodes
      $error("NODES must be a power of two, at least 2");
   end
   if (LINES < 2 || (1 << LINE_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end

   line_state_e       a_st, b_st, a_st_n, b_st_n;
   logic [NODE_W-1:0] a_own, b_own, a_own_n, b_own_n;
   logic [NODES-1:0]  a_vec, b_vec, a_vec_n, b_vec_n;
   logic [NODE_W-1:0] a_pend, b_pend, a_pend_n, b_pend_n;
   logic              a_wr, b_wr;
   rsp_kind_e         rk;
   logic [NODE_W-1:0] fwd;
   logic [NODES-1:0]  inv;
   logic              take;

   // a message to the same line wins the cycle
   assign req_ready = !(msg_valid && (msg_line == req_line));
   assign take      = req_valid && req_ready;

   hd_store #(.LINES(LINES), .NODES(NODES), .NODE_W(NODE_W), .LINE_W(LINE_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_line(req_line), .a_st(a_st), .a_own(a_own), .a_vec(a_vec), .a_pend(a_pend),
      .a_we(take && a_wr), .a_st_n(a_st_n), .a_own_n(a_own_n), .a_vec_n(a_vec_n),
      .a_pend_n(a_pend_n),
      .b_line(msg_line), .b_st(b_st), .b_own(b_own), .b_vec(b_vec), .b_pend(b_pend),
      .b_we(msg_valid && b_wr), .b_st_n(b_st_n), .b_own_n(b_own_n), .b_vec_n(b_vec_n),
      .b_pend_n(b_pend_n)
   );

   hd_req_fsm #(.NODES(NODES), .NODE_W(NODE_W)) u_req (
      .kind(req_kind_e'(req_kind)), .node(req_node),
      .cur_st(a_st), .cur_own(a_own), .cur_vec(a_vec), .cur_pend(a_pend),
      .wr(a_wr), .nxt_st(a_st_n), .nxt_own(a_own_n), .nxt_vec(a_vec_n), .nxt_pend(a_pend_n),
      .rk(rk), .fwd(fwd), .inv(inv)
   );

   hd_msg_fsm #(.NODES(NODES), .NODE_W(NODE_W)) u_msg (
      .kind(msg_kind_e'(msg_kind)),
      .cur_st(b_st), .cur_own(b_own), .cur_vec(b_vec), .cur_pend(b_pend),
      .wr(b_wr), .nxt_st(b_st_n), .nxt_own(b_own_n), .nxt_vec(b_vec_n), .nxt_pend(b_pend_n)
   );

   // registered response stage
   logic              rv_q, iv_q;
   rsp_kind_e         rk_q;
   logic [NODE_W-1:0] rn_q, ro_q;
   logic [LINE_W-1:0] rl_q;
   logic [NODES-1:0]  im_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rv_q <= 1'b0;
         iv_q <= 1'b0;
         rk_q <= RS_IDLE;
         rn_q <= '0;
         ro_q <= '0;
         rl_q <= '0;
         im_q <= '0;
      end else begin
         rv_q <= take;
         iv_q <= take && (inv != '0);
         rk_q <= take ? rk : RS_IDLE;
         rn_q <= req_node;
         ro_q <= fwd;
         rl_q <= req_line;
         im_q <= take ? inv : '0;
      end
   end

   assign rsp_valid = rv_q;
   assign rsp_kind  = rk_q;
   assign rsp_node  = rn_q;
   assign rsp_owner = ro_q;
   assign rsp_line  = rl_q;
   assign inv_valid = iv_q;
   assign inv_mask  = im_q;
   assign inv_line  = rl_q;

   // R11
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);
   // R11
   no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !rsp_valid);
   // R11
   collide_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && req_valid && msg_line == req_line) |-> !req_ready);
   // R5
   inv_with_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> (rsp_valid && (rsp_kind == RS_EXDATA || rsp_kind == RS_UPACK)));
   // R5
   inv_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> (inv_mask[rsp_node] == 1'b0 && inv_mask != '0));
   // R4
   fwd_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind == RS_FWD) |-> (rsp_owner != rsp_node));

endmodule

// File: tb/coh_home_dir_tb.sv
module coh_home_dir_tb;
   import home_dir_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = '0;
   logic [3:0]  req_node = '0;
   logic [5:0]  req_line = '0;
   logic        msg_valid = 1'b0;
   logic [1:0]  msg_kind = '0;
   logic [5:0]  msg_line = '0;
   logic        rsp_valid;
   logic [2:0]  rsp_kind;
   logic [3:0]  rsp_node;
   logic [5:0]  rsp_line;
   logic [3:0]  rsp_owner;
   logic        inv_valid;
   logic [15:0] inv_mask;
   logic [5:0]  inv_line;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct packed {
      logic [2:0]  kind;
      logic [3:0]  node;
      logic [5:0]  line;
      logic [3:0]  own;
      logic [15:0] inv;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   coh_home_dir u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_node(req_node), .req_line(req_line),
      .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_line(msg_line),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node),
      .rsp_line(rsp_line), .rsp_owner(rsp_owner),
      .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_line(inv_line)
   );

   // monitor: pops the scoreboard as responses appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (inv_valid && !rsp_valid) begin
            total++; bad++;
            $display("FAIL R5: inv_valid=1 without response, exp no invalidation");
         end
         if (rsp_valid) begin
            total++;
            if (exp_q.size() == 0) begin
               bad++;
               $display("FAIL R11: stray response kind=%0d line=%0d, exp none", rsp_kind, rsp_line);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (rsp_kind !== e.kind || rsp_node !== e.node || rsp_line !== e.line ||
                   (e.kind == RS_FWD && rsp_owner !== e.own) ||
                   inv_valid !== (e.inv != 16'h0) ||
                   (e.inv != 16'h0 && (inv_mask !== e.inv || inv_line !== e.line))) begin
                  bad++;
                  $display("FAIL %s: got kind=%0d node=%0d line=%0d own=%0d inv=%b/%h exp kind=%0d node=%0d line=%0d own=%0d inv=%h",
                           t, rsp_kind, rsp_node, rsp_line, rsp_owner, inv_valid, inv_mask,
                           e.kind, e.node, e.line, e.own, e.inv);
               end
            end
         end
      end
   end

   task automatic expect_rsp(input logic [2:0] ek, input int n, input int l, input int eo,
                             input logic [15:0] ei, input string tag);
      exp_t e;
      e.kind = ek; e.node = 4'(n); e.line = 6'(l); e.own = 4'(eo); e.inv = ei;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // driver: one request, expected reply queued
   task automatic do_req(input logic [1:0] k, input int n, input int l, input logic [2:0] ek,
                         input int eo, input logic [15:0] ei, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_node = 4'(n); req_line = 6'(l);
      expect_rsp(ek, n, l, eo, ei, tag);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      total++;
      if (rsp_valid !== 1'b1) begin
         bad++;
         $display("FAIL R11: rsp_valid=%b one clock after accept, exp 1", rsp_valid);
      end
   endtask

   task automatic do_msg(input logic [1:0] k, input int l);
      @(negedge clk);
      msg_valid = 1'b1; msg_kind = k; msg_line = 6'(l);
      @(posedge clk);
      #1;
      msg_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: run did not finish, exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      total++;
      if (rsp_valid !== 1'b0 || inv_valid !== 1'b0 || req_ready !== 1'b1) begin
         bad++;
         $display("FAIL R1: rsp_valid=%b inv_valid=%b req_ready=%b exp 0 0 1",
                  rsp_valid, inv_valid, req_ready);
      end

      // R2 / R7 on line 1
      do_req(2'd0, 3, 1, RS_DATA,   0, 16'h0, "R2 read unowned");
      do_req(2'd0, 3, 1, RS_DATA,   0, 16'h0, "R7 owner read");
      do_req(2'd2, 3, 1, RS_UPACK,  0, 16'h0, "R7 owner upgrade");
      do_req(2'd1, 3, 1, RS_EXDATA, 0, 16'h0, "R7 owner rdex");

      // R4 / R8 / R10 / R3 / R5 on line 2
      do_req(2'd0, 1, 2, RS_DATA, 0, 16'h0, "R2 read unowned line2");
      do_req(2'd0, 2, 2, RS_FWD,  1, 16'h0, "R4 read to exclusive");
      do_req(2'd0, 4, 2, RS_NACK, 0, 16'h0, "R8 read busy-shared");
      do_req(2'd2, 5, 2, RS_NACK, 0, 16'h0, "R8 upgrade busy-shared");
      do_msg(2'd1, 2);
      do_req(2'd0, 6, 2, RS_NACK, 0, 16'h0, "R10 transfer ignored in busy-shared");
      do_msg(2'd0, 2);
      do_req(2'd0, 7, 2, RS_DATA,   0, 16'h0,  "R3 read shared");
      do_req(2'd1, 2, 2, RS_EXDATA, 0, 16'h0082, "R5 rdex invalidates 1 and 7");
      do_msg(2'd0, 2);
      do_req(2'd0, 9, 2, RS_FWD,  2, 16'h0, "R10 writeback ignored on exclusive");
      do_msg(2'd0, 2);
      do_req(2'd2, 9, 2, RS_UPACK, 0, 16'h0004, "R5 upgrade invalidates 2");

      // R6 on line 3
      do_req(2'd0, 0, 3, RS_DATA, 0, 16'h0, "R2 read unowned line3");
      do_req(2'd1, 5, 3, RS_FWD,  0, 16'h0, "R6 rdex to exclusive");
      do_req(2'd0, 6, 3, RS_NACK, 0, 16'h0, "R8 read busy-exclusive");
      do_msg(2'd0, 3);
      do_req(2'd0, 6, 3, RS_NACK, 0, 16'h0, "R10 writeback ignored in busy-exclusive");
      do_msg(2'd1, 3);
      do_req(2'd0, 8, 3, RS_FWD,  5, 16'h0, "R6 transfer made node5 owner");

      // R4 sharer set on line 4
      do_req(2'd0, 4,  4, RS_DATA, 0, 16'h0, "R2 read unowned line4");
      do_req(2'd0, 10, 4, RS_FWD,  4, 16'h0, "R4 forward to node4");
      do_msg(2'd0, 4);
      do_req(2'd2, 4, 4, RS_UPACK, 0, 16'h0400, "R4 writeback left 4 and 10 sharing");

      // R12
      do_req(2'd1, 11, 5, RS_EXDATA, 0,  16'h0, "R12 rdex unowned");
      do_req(2'd2, 12, 6, RS_EXDATA, 0,  16'h0, "R12 upgrade unowned");
      do_req(2'd0, 13, 6, RS_FWD,    12, 16'h0, "R12 upgrader became owner");

      // R9 poison paths
      do_msg(2'd2, 1);
      do_req(2'd0, 3, 1, RS_BERR, 0, 16'h0, "R9 owner read poisoned");
      do_req(2'd1, 0, 1, RS_BERR, 0, 16'h0, "R9 rdex poisoned");
      do_msg(2'd2, 6);
      do_req(2'd0, 1, 6, RS_NACK, 0, 16'h0, "R9 wait line nacks");
      do_msg(2'd0, 6);
      do_req(2'd0, 1, 6, RS_BERR, 0, 16'h0, "R9 wait then writeback poisons");
      do_msg(2'd2, 7);
      do_req(2'd2, 2, 7, RS_BERR, 0, 16'h0, "R9 unowned poisoned");
      do_msg(2'd3, 9);
      do_req(2'd0, 1, 9, RS_DATA, 0, 16'h0, "R10 no-op message left line9 unowned");

      // R11 same-line collision on line 8
      do_req(2'd0, 2, 8, RS_DATA, 0, 16'h0, "R2 read unowned line8");
      @(negedge clk);
      msg_valid = 1'b1; msg_kind = 2'd2; msg_line = 6'd8;
      req_valid = 1'b1; req_kind = 2'd0; req_node = 4'd1; req_line = 6'd8;
      expect_rsp(RS_BERR, 1, 8, 0, 16'h0, "R11 message applied before stalled request");
      #1;
      total++;
      if (req_ready !== 1'b0) begin
         bad++;
         $display("FAIL R11: req_ready=%b on same-line collision, exp 0", req_ready);
      end
      @(posedge clk);
      #1;
      msg_valid = 1'b0;
      @(negedge clk);
      total++;
      if (req_ready !== 1'b1) begin
         bad++;
         $display("FAIL R11: req_ready=%b after message, exp 1", req_ready);
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;

      // R11 different lines in the same cycle (line 9 owned by node 1)
      @(negedge clk);
      msg_valid = 1'b1; msg_kind = 2'd2; msg_line = 6'd10;
      req_valid = 1'b1; req_kind = 2'd0; req_node = 4'd2; req_line = 6'd9;
      expect_rsp(RS_FWD, 2, 9, 1, 16'h0, "R11 request taken beside other-line message");
      #1;
      total++;
      if (req_ready !== 1'b1) begin
         bad++;
         $display("FAIL R11: req_ready=%b for different lines, exp 1", req_ready);
      end
      @(posedge clk);
      #1;
      msg_valid = 1'b0; req_valid = 1'b0;
      do_req(2'd0, 5, 10, RS_BERR, 0, 16'h0, "R11 other-line message applied");

      repeat (3) @(negedge clk);
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R11: %0d responses missing, exp 0", exp_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule